// File: doc/BRIEF.md
# Pipeline Bypass and Hazard Control Unit

This block is the hazard controller for a five-stage, in-order pipeline made of fetch, decode, execute, memory-access and write-back stages. It is purely combinational. Each cycle it looks at the two source register numbers of the instruction now in execute. It compares them with the destinations of the two older instructions in the memory and write-back stages. From that it chooses, for each operand, whether the execute stage reads the register file value, the memory-stage result or the write-back result.

The same unit produces the enables and synchronous clears of the pipeline registers. A load in the memory stage whose destination feeds the instruction in execute causes a one-cycle stall. The program counter, the fetch/decode register and the decode/execute register hold through their enables. The register that feeds the memory stage is cleared, so a bubble enters memory access. A branch resolved as taken in execute clears the fetch/decode and decode/execute registers, which turns the two wrong-path instructions into no-ops, and lets the program counter load the target. All pins are plain control signals with no handshake. Datapath muxes, register file and ALU live outside.

Top module: `hazard_fwd_unit`

## Requirements
- R1: Each operand select output carries one of three codes: 2'b00 selects the register file, 2'b01 selects the write-back result, 2'b10 selects the memory-stage result. 2'b11 never appears.
- R2: Operand A selects the memory stage (2'b10) when `mem_wr_en` is 1, `mem_dst` is nonzero and `mem_dst` equals `ex_src_a`.
- R3: Operand A selects write-back (2'b01) when `wb_wr_en` is 1, `wb_dst` is nonzero, `wb_dst` equals `ex_src_a`, and the R2 condition is false.
- R4: When the memory and write-back stages both match a source, the memory stage is selected.
- R5: A destination of register 0 never produces a bypass, even with its write enable high.
- R6: Operand B follows the rules of R2 to R5 using `ex_src_b`, independently of operand A.
- R7: Load-use stall: `mem_is_load`, `mem_wr_en`, `mem_dst` nonzero and `mem_dst` equal to either source, with `br_taken` low. The unit then drives `pc_en`, `ifid_en` and `idex_en` to 0, `exmem_clr` to 1, and both other clears to 0.
- R8: A memory-stage instruction that is not a load, has write enable low, has destination 0, or matches neither source causes no stall. With `br_taken` low, all enables are then 1 and all clears 0.
- R9: With `br_taken` high the unit drives `ifid_clr` and `idex_clr` to 1, `exmem_clr` to 0, and `pc_en`, `ifid_en` and `idex_en` to 1.
- R10: With `br_taken` low and no load-use condition, no clear is asserted.
- R11: A taken branch overrides a load-use condition in the same cycle, so the outputs are exactly those of R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | REG_AW | First source register of the execute-stage instruction |
| ex_src_b | input | REG_AW | Second source register of the execute-stage instruction |
| mem_dst | input | REG_AW | Destination register of the memory-stage instruction |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| wb_dst | input | REG_AW | Destination register of the write-back-stage instruction |
| wb_wr_en | input | 1 | Write-back-stage instruction writes a register |
| br_taken | input | 1 | Branch in execute resolved as taken |
| fwd_sel_a | output | 2 | Bypass select for operand A |
| fwd_sel_b | output | 2 | Bypass select for operand B |
| pc_en | output | 1 | Program counter load enable |
| ifid_en | output | 1 | Fetch/decode register enable |
| idex_en | output | 1 | Decode/execute register enable |
| ifid_clr | output | 1 | Fetch/decode synchronous clear |
| idex_clr | output | 1 | Decode/execute synchronous clear |
| exmem_clr | output | 1 | Execute/memory synchronous clear |

## Verification
The bench builds the unit with the default address width of five bits. It draws most register numbers from 0 to 3, so matches, double matches and register 0 come up often, and it also uses register 31 to exercise the upper address bits. Directed vectors cover the back-to-back dependence, the distance-two dependence, a write to register 0, a load followed at once by its consumer on either operand, and a taken branch that collides with a load-use condition.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  typedef enum logic [1:0] {
    BYP_NONE = 2'b00,
    BYP_WB   = 2'b01,
    BYP_MEM  = 2'b10
  } byp_sel_e;

  localparam int unsigned NUM_SRC = 2;
endpackage

// File: rtl/fwd_select.sv
module fwd_select
  import hazard_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_wr_en,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic              wb_wr_en,
  output byp_sel_e          sel
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic mem_hit;
  logic wb_hit;

  assign mem_hit = mem_wr_en && (mem_dst != ZERO_REG) && (mem_dst == src);
  assign wb_hit  = wb_wr_en  && (wb_dst  != ZERO_REG) && (wb_dst  == src);

  always_comb begin
    sel = BYP_NONE;
    if (mem_hit)     sel = BYP_MEM;
    else if (wb_hit) sel = BYP_WB;
  end

  always_comb begin
    a_r1_legal_code: assert (sel != 2'b11);
    a_r4_mem_first: assert (!(mem_hit && wb_hit) || sel == BYP_MEM);
    a_r5_no_zero_bypass: assert (src != ZERO_REG || sel == BYP_NONE);
  end
endmodule

// File: rtl/loaduse_detect.sv
module loaduse_detect
  import hazard_pkg::*;
#(
  parameter int unsigned REG_AW = 5,
  parameter int unsigned N_SRC  = NUM_SRC
) (
  input  logic [REG_AW-1:0] srcs [N_SRC],
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_wr_en,
  input  logic              mem_is_load,
  output logic              hazard
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic [N_SRC-1:0] hit;
  logic             load_writes;

  assign load_writes = mem_is_load && mem_wr_en && (mem_dst != ZERO_REG);

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign hit[g] = load_writes && (mem_dst == srcs[g]);
  end

  assign hazard = |hit;

  always_comb begin
    a_r8_needs_load: assert (mem_is_load || !hazard);
  end
endmodule

// File: rtl/stage_ctrl.sv
module stage_ctrl (
  input  logic load_hz,
  input  logic br_taken,
  output logic pc_en,
  output logic ifid_en,
  output logic idex_en,
  output logic ifid_clr,
  output logic idex_clr,
  output logic exmem_clr
);
  logic stall;

  assign stall = load_hz && !br_taken;

  always_comb begin
    pc_en     = !stall;
    ifid_en   = !stall;
    idex_en   = !stall;
    ifid_clr  = br_taken;
    idex_clr  = br_taken;
    exmem_clr = stall;
  end

  always_comb begin
    a_r7_freeze_front: assert (!(load_hz && !br_taken) || (!pc_en && !ifid_en && exmem_clr));
    a_r9_flush_pair: assert (ifid_clr == idex_clr);
    a_r11_branch_wins: assert (!br_taken || (pc_en && !exmem_clr));
    a_r10_no_stray_clear: assert (br_taken || load_hz || !(ifid_clr || idex_clr || exmem_clr));
  end
endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
  import hazard_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] ex_src_a,
  input  logic [REG_AW-1:0] ex_src_b,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_wr_en,
  input  logic              mem_is_load,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic              wb_wr_en,
  input  logic              br_taken,
  output logic [1:0]        fwd_sel_a,
  output logic [1:0]        fwd_sel_b,
  output logic              pc_en,
  output logic              ifid_en,
  output logic              idex_en,
  output logic              ifid_clr,
  output logic              idex_clr,
  output logic              exmem_clr
);
  logic [REG_AW-1:0] srcs [NUM_SRC];
  byp_sel_e          sels [NUM_SRC];
  logic              load_hz;

  assign srcs[0] = ex_src_a;
  assign srcs[1] = ex_src_b;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_opnd
    fwd_select #(.REG_AW(REG_AW)) i_sel (
      .src       (srcs[g]),
      .mem_dst   (mem_dst),
      .mem_wr_en (mem_wr_en),
      .wb_dst    (wb_dst),
      .wb_wr_en  (wb_wr_en),
      .sel       (sels[g])
    );
  end

  assign fwd_sel_a = sels[0];
  assign fwd_sel_b = sels[1];

  loaduse_detect #(.REG_AW(REG_AW), .N_SRC(NUM_SRC)) i_lu (
    .srcs        (srcs),
    .mem_dst     (mem_dst),
    .mem_wr_en   (mem_wr_en),
    .mem_is_load (mem_is_load),
    .hazard      (load_hz)
  );

  stage_ctrl i_ctrl (
    .load_hz   (load_hz),
    .br_taken  (br_taken),
    .pc_en     (pc_en),
    .ifid_en   (ifid_en),
    .idex_en   (idex_en),
    .ifid_clr  (ifid_clr),
    .idex_clr  (idex_clr),
    .exmem_clr (exmem_clr)
  );

  always_comb begin
    a_r6_shared_mem_hit: assert (!(ex_src_a == ex_src_b) || fwd_sel_a == fwd_sel_b);
  end
endmodule

// File: tb/test_hazard_fwd_unit.sv
`timescale 1ns/1ps
module test_hazard_fwd_unit;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [AW-1:0] src_a, src_b, mdst, wdst;
  logic mwe, mld, wwe, br;
  logic [1:0] sel_a, sel_b;
  logic pc_en, ifid_en, idex_en, ifid_clr, idex_clr, exmem_clr;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  hazard_fwd_unit #(.REG_AW(AW)) i_hazard_fwd_unit (
    .ex_src_a(src_a), .ex_src_b(src_b), .mem_dst(mdst), .mem_wr_en(mwe),
    .mem_is_load(mld), .wb_dst(wdst), .wb_wr_en(wwe), .br_taken(br),
    .fwd_sel_a(sel_a), .fwd_sel_b(sel_b), .pc_en(pc_en), .ifid_en(ifid_en),
    .idex_en(idex_en), .ifid_clr(ifid_clr), .idex_clr(idex_clr), .exmem_clr(exmem_clr)
  );

  function automatic logic [1:0] ref_sel(int s, int md, bit me, int wd, bit we);
    if (me && md != 0 && md == s) return 2'b10;
    if (we && wd != 0 && wd == s) return 2'b01;
    return 2'b00;
  endfunction

  // expected {pc_en, ifid_en, idex_en, ifid_clr, idex_clr, exmem_clr}
  function automatic logic [5:0] ref_ctrl(int a, int b, int md, bit me, bit ld, bit t);
    bit hz;
    hz = ld && me && md != 0 && (md == a || md == b);
    if (t)  return 6'b111_110;
    if (hz) return 6'b000_001;
    return 6'b111_000;
  endfunction

  task automatic drive(int a, int b, int md, bit me, bit ld, int wd, bit we, bit t);
    src_a = AW'(a); src_b = AW'(b); mdst = AW'(md); mwe = me; mld = ld;
    wdst = AW'(wd); wwe = we; br = t;
  endtask

  task automatic check(string tag);
    logic [1:0] ea, eb;
    logic [5:0] ec, ac;
    ea = ref_sel(int'(src_a), int'(mdst), mwe, int'(wdst), wwe);
    eb = ref_sel(int'(src_b), int'(mdst), mwe, int'(wdst), wwe);
    ec = ref_ctrl(int'(src_a), int'(src_b), int'(mdst), mwe, mld, br);
    ac = {pc_en, ifid_en, idex_en, ifid_clr, idex_clr, exmem_clr};
    n_run++;
    if (sel_a !== ea || sel_b !== eb || ac !== ec) begin
      n_fail++;
      $display("FAIL %s: sel_a=%b sel_b=%b ctrl=%b expected sel_a=%b sel_b=%b ctrl=%b",
               tag, sel_a, sel_b, ac, ea, eb, ec);
    end
  endtask

  task automatic step(int a, int b, int md, bit me, bit ld, int wd, bit we, bit t, string tag);
    @(negedge clk);
    drive(a, b, md, me, ld, wd, we, t);
    @(posedge clk);
    #1 check(tag);
  endtask

  function automatic int pick();
    int r;
    r = int'($urandom_range(0, 9));
    if (r == 9) return AW'(31);
    return r % 4;
  endfunction

  initial begin
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 0, 0, 0, "R8 R10 idle after reset");
    // back-to-back dependence: MEM bypass
    step(5, 2, 5, 1, 0, 0, 0, 0, "R2 back-to-back operand A");
    step(3, 5, 5, 1, 0, 0, 0, 0, "R6 back-to-back operand B");
    // distance-two dependence: WB bypass
    step(7, 1, 4, 1, 0, 7, 1, 0, "R3 distance-two operand A");
    step(1, 7, 4, 1, 0, 7, 1, 0, "R6 distance-two operand B");
    step(6, 6, 6, 1, 0, 6, 1, 0, "R4 MEM beats WB");
    step(6, 6, 6, 0, 0, 6, 1, 0, "R3 MEM write disabled falls to WB");
    step(6, 9, 6, 1, 0, 9, 1, 0, "R1 R6 mixed codes");
    // register 0
    step(0, 0, 0, 1, 1, 0, 1, 0, "R5 register zero no bypass no stall");
    // load then immediate consumer
    step(8, 3, 8, 1, 1, 0, 0, 0, "R7 load-use operand A");
    step(2, 8, 8, 1, 1, 8, 1, 0, "R7 load-use operand B");
    step(8, 3, 8, 0, 1, 0, 0, 0, "R8 load without write");
    step(8, 3, 9, 1, 1, 0, 0, 0, "R8 load no match");
    step(8, 3, 8, 1, 0, 0, 0, 0, "R8 non-load match bypasses");
    // branches
    step(1, 2, 3, 1, 0, 4, 1, 1, "R9 taken branch flush");
    step(1, 2, 3, 1, 0, 4, 1, 0, "R10 not-taken no flush");
    step(8, 8, 8, 1, 1, 0, 0, 1, "R11 branch over load-use");
    step(31, 31, 31, 1, 1, 31, 1, 0, "R7 top register load-use");
    for (int i = 0; i < 3000; i++) begin
      step(pick(), pick(), pick(), 1'($urandom), 1'($urandom), pick(), 1'($urandom),
           1'($urandom_range(0, 5) == 0), "R1-mix random R2 R3 R4 R5 R6 R7 R9 R11");
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule